// File: doc/BRIEF.md
# Flash ADC Output Demultiplexer

This block is the digital back end of a high-speed flash converter. On every edge of the sample clock it takes one 8-bit conversion code and places it on two 8-bit output ports. A mode input selects between two ways of doing this.

In paired mode, the sample clock is divided by two. Consecutive samples are split between port A and port B. Both ports change together once every two sample clocks, so each A/B pair forms one aligned 16-bit word. The clock output is the divided clock, placed so that its rising edge falls in the middle of each word's valid window. In single-lane mode, every sample goes to port A at the full clock rate, and the clock output is the sample clock inverted.

An active-low synchronous reset puts the divider into a known phase. Several converters can then share one reset pulse and agree on which sample goes to which port. A polarity input chooses true binary output or bitwise-complemented output.

Top module: `adc_demux_out`

## Requirements
- R1: With `dmux_sel`=1, the first sample captured after reset release (or after entering paired mode) goes to `port_a` and the next one goes to `port_b`. The two ports update on the same clock edge, once every two sample clocks, and hold their values in between.
- R2: In paired mode, samples taken at edges k and k+1 appear together on `port_a`/`port_b` right after edge k+1, and not earlier.
- R3: With `dmux_sel`=0, `port_a` shows the sample taken at the most recent clock edge, updating every cycle, and `port_b` is 0.
- R4: `rst_n` is sampled on the rising clock edge. An edge with `rst_n`=0 clears both ports to 0 and returns the divider to the port-A phase. In paired mode, `clk_out` is then low.
- R5: In paired mode, `clk_out` is low for the sample period that starts at a port update and high for the next one. Its rising edge therefore comes one sample period after the data changes.
- R6: In single-lane mode, `clk_out` is the inverse of `clk`.
- R7: With `pol_true`=1, a code leaves the block unchanged (bottom of range 0, top 255). With `pol_true`=0, every bit is complemented (0 becomes 255, 255 becomes 0). The polarity in force at the edge where a sample is captured is the one applied to it.
- R8: Switching from single-lane to paired mode starts in the port-A phase. The first sample taken in paired mode lands on `port_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous divider reset |
| dmux_sel | input | 1 | 1 = paired (demultiplexed) mode, 0 = single-lane mode |
| pol_true | input | 1 | 1 = true binary output, 0 = complemented output |
| code_in | input | 8 | Conversion code from the comparator encoder |
| port_a | output | 8 | First lane (earlier sample of each pair) |
| port_b | output | 8 | Second lane (later sample of each pair) |
| clk_out | output | 1 | Divided clock (paired) or inverted sample clock (single-lane) |

## Verification
The bench checks the pair boundary right after reset. A design that starts in the wrong phase puts the first sample on port B, and one that updates the lanes on separate edges shows torn words. It asserts reset in the middle of a pair, on the odd phase, and then checks that the next pair realigns to port A. It switches from single-lane to paired mode and expects the first paired sample on port A, which catches a divider that keeps running in single-lane mode. It also sweeps the extreme codes under both polarities, and checks `clk_out` in both clock phases, which exposes a divided clock with the wrong phase or a straight clock that is not inverted.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

endpackage

// File: rtl/adc_code_polarity.sv
module adc_code_polarity #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              true_bin_i,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};

    always_comb begin
        if (true_bin_i) begin
            code_o = code_i;
        end else begin
            code_o = code_i ^ ALL_ONES;
        end
    end

endmodule

// File: rtl/adc_phase_div.sv
module adc_phase_div
    import adc_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dmux_en,
    output lane_e phase_o
);

    typedef struct packed {
        lane_e phase;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.phase = LANE_A;
        end else if (dmux_en) begin
            st_d.phase = (st_q.phase == LANE_A) ? LANE_B : LANE_A;
        end else begin
            st_d.phase = LANE_A;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R1: the divider alternates on every paired-mode edge
    p_phase_alternates_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dmux_en)) |-> (st_q.phase != $past(st_q.phase)));

    // R8: single-lane mode parks the divider on the port-A phase
    p_straight_parks_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dmux_en)) |-> (st_q.phase == LANE_A));

endmodule

// File: rtl/adc_lane_steer.sv
module adc_lane_steer
    import adc_demux_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmux_en,
    input  lane_e             phase_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] port_a_o,
    output logic [CODE_W-1:0] port_b_o
);

    localparam logic [CODE_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CODE_W-1:0] hold_a;
        logic [CODE_W-1:0] out_a;
        logic [CODE_W-1:0] out_b;
    } steer_state_t;

    steer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.hold_a = ZERO;
            st_d.out_a  = ZERO;
            st_d.out_b  = ZERO;
        end else if (dmux_en) begin
            if (phase_i == LANE_A) begin
                st_d.hold_a = code_i;
            end else begin
                st_d.out_a = st_q.hold_a;
                st_d.out_b = code_i;
            end
        end else begin
            st_d.out_a = code_i;
            st_d.out_b = ZERO;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign port_a_o = st_q.out_a;
    assign port_b_o = st_q.out_b;

    // R1: on a port-A phase edge in paired mode both lanes hold
    p_lanes_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dmux_en) && ($past(phase_i) == LANE_A))
        |-> ($stable(st_q.out_a) && $stable(st_q.out_b)));

    // R3: port B stays zero in single-lane mode
    p_b_zero_straight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dmux_en)) |-> (st_q.out_b == ZERO));

    // R2: the B lane takes the code presented at the completing edge
    p_b_gets_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dmux_en) && ($past(phase_i) == LANE_B))
        |-> (st_q.out_b == $past(code_i)));

endmodule

// File: rtl/adc_clk_out.sv
module adc_clk_out
    import adc_demux_pkg::*;
(
    input  logic  clk,
    input  logic  dmux_en,
    input  lane_e phase_i,
    output logic  clk_out_o
);

    always_comb begin
        if (dmux_en) begin
            clk_out_o = (phase_i == LANE_B);
        end else begin
            clk_out_o = ~clk;
        end
    end

endmodule

// File: rtl/adc_demux_out.sv
module adc_demux_out
    import adc_demux_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmux_sel,
    input  logic              pol_true,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] port_a,
    output logic [CODE_W-1:0] port_b,
    output logic              clk_out
);

    logic [CODE_W-1:0] code_pol;
    lane_e             phase;

    adc_code_polarity #(.CODE_W(CODE_W)) u_pol (
        .code_i     (code_in),
        .true_bin_i (pol_true),
        .code_o     (code_pol)
    );

    adc_phase_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .dmux_en (dmux_sel),
        .phase_o (phase)
    );

    adc_lane_steer #(.CODE_W(CODE_W)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .dmux_en  (dmux_sel),
        .phase_i  (phase),
        .code_i   (code_pol),
        .port_a_o (port_a),
        .port_b_o (port_b)
    );

    adc_clk_out u_cko (
        .clk       (clk),
        .dmux_en   (dmux_sel),
        .phase_i   (phase),
        .clk_out_o (clk_out)
    );

    // R4: a reset edge clears both ports
    p_reset_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (port_a == '0 && port_b == '0));

endmodule

// File: tb/adc_demux_out_test.sv
module adc_demux_out_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dmux_sel = 1'b1;
    logic       pol_true = 1'b1;
    logic [7:0] code_in = 8'h00;
    logic [7:0] port_a, port_b;
    logic       clk_out;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R4";

    int ea = 0, eb = 0, ediv = 0;
    int pend[$];

    always #4 clk = ~clk;

    adc_demux_out uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dmux_sel (dmux_sel),
        .pol_true (pol_true),
        .code_in  (code_in),
        .port_a   (port_a),
        .port_b   (port_b),
        .clk_out  (clk_out)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, updated at each sample edge
    always @(posedge clk) begin
        int c;
        c = pol_true ? int'(code_in) : (255 - int'(code_in));
        if (!rst_n) begin
            ea = 0; eb = 0; pend.delete();
        end else if (dmux_sel) begin
            pend.push_back(c);
            if (pend.size() == 2) begin
                ea = pend[0]; eb = pend[1]; pend.delete();
            end
        end else begin
            ea = c; eb = 0; pend.delete();
        end
        ediv = (pend.size() == 1) ? 1 : 0;
        #2;
        check(tag, "port_a", int'(port_a), ea);
        check(tag, "port_b", int'(port_b), eb);
        if (dmux_sel) check("R5", "clk_out high phase", int'(clk_out), ediv);
        else          check("R6", "clk_out high phase", int'(clk_out), 0);
        #3;
        if (dmux_sel) check("R5", "clk_out low phase", int'(clk_out), ediv);
        else          check("R6", "clk_out low phase", int'(clk_out), 1);
    end

    task automatic step(input logic [7:0] c);
        @(posedge clk);
        #6;
        code_in = c;
    endtask

    initial begin
        // R4: reset from time zero
        tag = "R4";
        code_in = 8'h5A;
        repeat (3) step(8'h5A);
        // R2: first pair after release
        rst_n = 1'b1; tag = "R2";
        code_in = 8'h11;
        step(8'h22); step(8'h33); step(8'h44); step(8'h55);
        // R1: general paired stream
        tag = "R1";
        for (int i = 0; i < 40; i++) step(8'((i * 37 + 5) & 255));
        // R7: complemented output with extreme codes, paired mode
        tag = "R7"; pol_true = 1'b0;
        step(8'h00); step(8'hFF); step(8'hFF); step(8'h00);
        for (int i = 0; i < 16; i++) step(8'((i * 53 + 9) & 255));
        // R3: single-lane mode
        tag = "R3"; pol_true = 1'b1; dmux_sel = 1'b0;
        step(8'h00); step(8'hFF);
        for (int i = 0; i < 28; i++) step(8'((i * 29 + 3) & 255));
        // R7: complemented output in single-lane mode
        tag = "R7"; pol_true = 1'b0;
        step(8'hFF); step(8'h00);
        for (int i = 0; i < 8; i++) step(8'((i * 71 + 1) & 255));
        // R8: enter paired mode, first sample goes to port A
        tag = "R8"; pol_true = 1'b1; dmux_sel = 1'b1;
        step(8'hA1); step(8'hB2); step(8'hC3);
        for (int i = 0; i < 7; i++) step(8'((i * 13 + 7) & 255));
        // R4: reset mid-pair on the odd phase
        tag = "R4";
        step(8'h66);
        rst_n = 1'b0;
        step(8'h77); step(8'h88);
        rst_n = 1'b1; tag = "R1";
        step(8'h99);
        for (int i = 0; i < 20; i++) step(8'((i * 97 + 11) & 255));
        @(posedge clk); #7;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule